// File: doc/BRIEF.md
# Interrupt and Exception Entry Controller

This block decides, at each decision point offered by the instruction sequencer, whether the processor enters an exception handler. It forms a 16-bit cause code, either from a synchronous exception code that is pending or from the highest-numbered active interrupt request line. It then performs the entry. It picks one of three tiers from the status word, saves the return state, computes the handler address and produces the updated status word. The sequencer applies these outputs and resumes fetching at the new PC.

The three tiers are set by the status word. A regular entry writes the normal save registers and uses a code-derived vector. A duplexed entry (an exception taken while one is already being serviced) writes the fatal-side save registers and uses a fixed vector. A fatal entry writes no save register. Instead it dumps three words to memory through a simple valid/acknowledge port, and holds `busy` until all three are acknowledged.

The controller has two states. In `ST_IDLE` it evaluates `accept`. The transition `IDLE_TO_IDLE` completes a regular or duplexed entry in one cycle, and `IDLE_TO_DUMP` starts a fatal entry. In `ST_DUMP` it presents dump words in order. The transition `DUMP_ADVANCE` moves to the next word on each acknowledge, and `DUMP_TO_IDLE` completes the entry on the acknowledge of the last word.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `entry_done`, `busy`, `dump_valid`, `norm_save_we` and `dup_save_we` are all 0.
- R2: Status word bit positions are: ID at 12, AE at 13, EP at 14, NP at 15, interrupt level at bits 19:16. An interrupt is taken only when all of these hold: `accept` is 1, `exc_code` is zero, some `irq_req` bit is 1, and ID, EP and NP are all 0. When no exception is pending and no interrupt qualifies, `accept` produces no entry.
- R3: The highest-numbered active request line wins. The cause code it forms is 0xFE00 OR (line number << 4).
- R4: A nonzero `exc_code` is taken whatever the request lines and the ID flag are, and its 16 bits are used unchanged as the cause code. A pending interrupt is not taken on that entry.
- R5: Regular tier (NP=0, EP=0): `norm_save_we` pulses, `save_pc`/`save_psw` carry the current PC and status word, `cause_code` carries the code, and `new_pc` = 0xFFFF0000 OR (code AND 0xFFF0).
- R6: A regular-tier vector of 0xFFFFFF70 is replaced by 0xFFFFFF60.
- R7: Duplexed tier (NP=0, EP=1): `dup_save_we` pulses with the same save data and cause code, and `new_pc` = 0xFFFFFFD0.
- R8: Fatal tier (NP=1): `busy` and `dump_valid` rise. Three words go out in order: address 0 carries 0xFFFF0000 OR code, address 4 carries the status word, and address 8 carries the PC. Each word is held unchanged until `dump_ack`. After the third acknowledge, `entry_done` pulses with `new_pc` = 0xFFFFFFD0 and no save write.
- R9: `new_psw` is the entry status word with AE cleared and ID set. When the code's upper byte is 0xFE, the interrupt level is also set to code bits 7:4. All other bits are unchanged.
- R10: A regular or duplexed entry raises `entry_done` and its outputs in the cycle after the `accept` edge. Save-register writes only occur together with `entry_done`.
- R11: `accept` has no effect while `busy` is 1. Inputs that change during a dump do not alter the words being dumped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 5 | Interrupt request lines, bit n is line n |
| exc_code | input | 16 | Pending synchronous exception code, zero when none |
| cur_pc | input | 32 | PC at the decision point |
| cur_psw | input | 32 | Status word at the decision point |
| accept | input | 1 | Decision-point strobe from the sequencer |
| dump_ack | input | 1 | Memory acknowledge for the current dump word |
| busy | output | 1 | Fatal dump in progress |
| entry_done | output | 1 | Entry complete: clear pending code, fetch from new_pc |
| new_pc | output | 32 | Handler address, valid with entry_done |
| new_psw | output | 32 | Updated status word, valid with entry_done |
| norm_save_we | output | 1 | Write normal save registers and normal cause half |
| dup_save_we | output | 1 | Write fatal save registers and fatal cause half |
| save_pc | output | 32 | PC to save |
| save_psw | output | 32 | Status word to save |
| cause_code | output | 16 | Cause code to store |
| dump_valid | output | 1 | Dump word request |
| dump_addr | output | 32 | Dump word byte address |
| dump_data | output | 32 | Dump word data |

## Verification
The assertions assume that `dump_ack` is only raised while `dump_valid` is 1, and that `accept` is low while reset is asserted. The stimulus raises the acknowledge only in dump cycles and holds `accept` at 0 through reset. It sweeps every request-line pattern against every combination of ID, EP and NP. Each sweep point is paired with a set of exception codes that covers no code, a plain code, an interrupt-style code and the remapped vector. In each fatal case, `accept` is left high during the dump and the inputs are changed mid-dump, so that the latched words are shown to be insensitive to both.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int PSW_ID    = 12;
    localparam int PSW_AE    = 13;
    localparam int PSW_EP    = 14;
    localparam int PSW_NP    = 15;
    localparam int PSW_IL_LO = 16;
    localparam int IL_W      = 4;

    localparam logic [7:0]  IRQ_CODE_HI = 8'hFE;
    localparam logic [31:0] VEC_BASE    = 32'hFFFF_0000;
    localparam logic [31:0] DUP_VEC     = 32'hFFFF_FFD0;
    localparam logic [31:0] REMAP_FROM  = 32'hFFFF_FF70;
    localparam logic [31:0] REMAP_TO    = 32'hFFFF_FF60;

    typedef enum logic [1:0] {
        TIER_REG   = 2'd0,
        TIER_DUP   = 2'd1,
        TIER_FATAL = 2'd2
    } tier_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DUMP = 1'b1
    } state_e;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_IRQ = 5,
    parameter int LVL_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0] req,
    output logic               any,
    output logic [LVL_W-1:0]   lvl
);
    // ascending scan: the last active line seen is the highest one
    always_comb begin
        lvl = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (req[i]) lvl = LVL_W'(i);
        end
    end

    assign any = |req;

    always_comb begin
        if (any) begin
            AST_LVL_ACTIVE: assert (req[lvl]);                       // R3
            AST_LVL_HIGHEST: assert ((req >> lvl) == NUM_IRQ'(1));   // R3
        end
    end
endmodule

// File: rtl/vector_unit.sv
module vector_unit
    import exc_pkg::*;
(
    input  logic [15:0] code,
    input  logic [31:0] psw,
    output tier_e       tier,
    output logic [31:0] handler_pc,
    output logic [31:0] upd_psw
);
    logic [31:0] raw_vec;

    always_comb begin
        if (psw[PSW_NP])      tier = TIER_FATAL;
        else if (psw[PSW_EP]) tier = TIER_DUP;
        else                  tier = TIER_REG;
    end

    assign raw_vec = VEC_BASE | {16'h0000, code & 16'hFFF0};

    always_comb begin
        unique case (tier)
            TIER_REG: handler_pc = (raw_vec == REMAP_FROM) ? REMAP_TO : raw_vec;
            default:  handler_pc = DUP_VEC;
        endcase
    end

    // level field is IL_W bits wide, so code[7:4] never exceeds 15
    always_comb begin
        upd_psw = psw;
        upd_psw[PSW_AE] = 1'b0;
        upd_psw[PSW_ID] = 1'b1;
        if (code[15:8] == IRQ_CODE_HI)
            upd_psw[PSW_IL_LO +: IL_W] = code[7:4];
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int NUM_IRQ    = 5,
    parameter int DUMP_WORDS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [15:0]        exc_code,
    input  logic [31:0]        cur_pc,
    input  logic [31:0]        cur_psw,
    input  logic               accept,
    input  logic               dump_ack,
    output logic               busy,
    output logic               entry_done,
    output logic [31:0]        new_pc,
    output logic [31:0]        new_psw,
    output logic               norm_save_we,
    output logic               dup_save_we,
    output logic [31:0]        save_pc,
    output logic [31:0]        save_psw,
    output logic [15:0]        cause_code,
    output logic               dump_valid,
    output logic [31:0]        dump_addr,
    output logic [31:0]        dump_data
);
    localparam int LVL_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int IDX_W = (DUMP_WORDS > 1) ? $clog2(DUMP_WORDS) : 1;

    state_e            state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [15:0]       lat_code;
    logic [31:0]       lat_pc, lat_psw, lat_newpsw;

    logic              irq_any, irq_ok, sync_pend, take, last_word;
    logic [LVL_W-1:0]  irq_lvl;
    logic [15:0]       code_sel;
    tier_e             tier;
    logic [31:0]       handler_pc, upd_psw;

    irq_arbiter #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_arb (
        .req (irq_req),
        .any (irq_any),
        .lvl (irq_lvl)
    );

    assign sync_pend = |exc_code;
    assign irq_ok    = irq_any & ~cur_psw[PSW_ID] & ~cur_psw[PSW_EP] & ~cur_psw[PSW_NP];
    assign code_sel  = sync_pend ? exc_code
                                 : ({IRQ_CODE_HI, 8'h00} | (16'(irq_lvl) << 4));
    assign take      = accept && (state_q == ST_IDLE) && (sync_pend || irq_ok);
    assign last_word = (idx_q == IDX_W'(DUMP_WORDS - 1));

    vector_unit u_vec (
        .code       (code_sel),
        .psw        (cur_psw),
        .tier       (tier),
        .handler_pc (handler_pc),
        .upd_psw    (upd_psw)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take && tier == TIER_FATAL) state_d = ST_DUMP;
            ST_DUMP: if (dump_ack && last_word)      state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and dump context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            lat_code   <= '0;
            lat_pc     <= '0;
            lat_psw    <= '0;
            lat_newpsw <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                idx_q <= '0;
                if (take) begin
                    lat_code   <= code_sel;
                    lat_pc     <= cur_pc;
                    lat_psw    <= cur_psw;
                    lat_newpsw <= upd_psw;
                end
            end else if (dump_ack) begin
                idx_q <= last_word ? '0 : idx_q + 1'b1;
            end
        end
    end

    // registered entry outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_done   <= 1'b0;
            norm_save_we <= 1'b0;
            dup_save_we  <= 1'b0;
            new_pc       <= '0;
            new_psw      <= '0;
            save_pc      <= '0;
            save_psw     <= '0;
            cause_code   <= '0;
        end else begin
            entry_done   <= 1'b0;
            norm_save_we <= 1'b0;
            dup_save_we  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        save_pc    <= cur_pc;
                        save_psw   <= cur_psw;
                        cause_code <= code_sel;
                        if (tier != TIER_FATAL) begin
                            entry_done   <= 1'b1;
                            new_pc       <= handler_pc;
                            new_psw      <= upd_psw;
                            norm_save_we <= (tier == TIER_REG);
                            dup_save_we  <= (tier == TIER_DUP);
                        end
                    end
                end
                ST_DUMP: begin
                    if (dump_ack && last_word) begin
                        entry_done <= 1'b1;
                        new_pc     <= DUP_VEC;
                        new_psw    <= lat_newpsw;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy       = (state_q == ST_DUMP);
    assign dump_valid = busy;
    assign dump_addr  = {{(30 - IDX_W){1'b0}}, idx_q, 2'b00};

    always_comb begin
        unique case (idx_q)
            IDX_W'(0): dump_data = {16'hFFFF, lat_code};
            IDX_W'(1): dump_data = lat_psw;
            default:   dump_data = lat_pc;
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !entry_done && !busy && !norm_save_we && !dup_save_we);   // R1
    AST_SAVE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_save_we || dup_save_we) |-> entry_done);                       // R10
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> $past(accept) || $past(dump_ack));                    // R10
    AST_PSW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> new_psw[PSW_ID] && !new_psw[PSW_AE]);                 // R9
    AST_NO_RAW_FIV: assert property (@(posedge clk) disable iff (!rst_n)
        norm_save_we |-> new_pc != REMAP_FROM);                              // R6
    AST_DUP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        dup_save_we |-> new_pc == DUP_VEC);                                  // R7
    AST_DUMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dump_valid && !dump_ack |=> dump_valid && $stable(dump_addr) && $stable(dump_data)); // R8
    AST_DUMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dump_valid |-> dump_addr < 32'(4 * DUMP_WORDS));                     // R8
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(accept));                                      // R11
endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  irq_req = '0;
    logic [15:0] exc_code = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_psw = '0;
    logic        accept = 1'b0;
    logic        dump_ack = 1'b0;
    logic        busy, entry_done, norm_save_we, dup_save_we, dump_valid;
    logic [31:0] new_pc, new_psw, save_pc, save_psw, dump_addr, dump_data;
    logic [15:0] cause_code;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    exc_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .exc_code(exc_code),
        .cur_pc(cur_pc), .cur_psw(cur_psw), .accept(accept), .dump_ack(dump_ack),
        .busy(busy), .entry_done(entry_done), .new_pc(new_pc), .new_psw(new_psw),
        .norm_save_we(norm_save_we), .dup_save_we(dup_save_we), .save_pc(save_pc),
        .save_psw(save_psw), .cause_code(cause_code), .dump_valid(dump_valid),
        .dump_addr(dump_addr), .dump_data(dump_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_psw(input logic [31:0] p, input logic [15:0] c);
        logic [31:0] r;
        r = (p & ~32'h0000_2000) | 32'h0000_1000;
        if (c[15:8] == 8'hFE) r = (r & ~32'h000F_0000) | (32'(c[7:4]) << 16);
        return r;
    endfunction

    task automatic run_vec(input logic [4:0] irq, input logic [2:0] fl, input logic [15:0] ec, input logic [31:0] pc);
        logic [31:0] psw;
        logic [15:0] code;
        logic [31:0] vec;
        bit id, ep, np, take;
        int hi;
        psw = 32'h0005_2A05 | (32'(fl[0]) << 12) | (32'(fl[1]) << 14) | (32'(fl[2]) << 15);
        id = fl[0]; ep = fl[1]; np = fl[2];
        hi = 0;
        for (int i = 0; i < 5; i++) if (irq[i]) hi = i;
        take = (ec != 0) || (irq != 0 && !id && !ep && !np);
        code = (ec != 0) ? ec : (16'hFE00 | 16'(hi << 4));
        vec = 32'hFFFF_0000 | {16'h0, code & 16'hFFF0};
        if (vec == 32'hFFFF_FF70) vec = 32'hFFFF_FF60;

        @(negedge clk);
        irq_req = irq; exc_code = ec; cur_pc = pc; cur_psw = psw; accept = 1'b1;
        @(negedge clk);
        accept = np && take;   // R11: keep strobing during the dump
        if (!take) begin
            chk(!entry_done && !busy, "R2 no entry", {30'h0, entry_done, busy}, 32'h0);
        end else if (!np) begin
            chk(entry_done, "R10 done timing", 32'(entry_done), 32'h1);
            chk(cause_code == code, "R3/R4 cause code", 32'(cause_code), 32'(code));
            chk(save_pc == pc && save_psw == psw, "R5 save data", save_pc, pc);
            chk(new_psw == exp_psw(psw, code), "R9 new psw", new_psw, exp_psw(psw, code));
            if (ep) begin
                chk(dup_save_we && !norm_save_we, "R7 dup write", {30'h0, dup_save_we, norm_save_we}, 32'h2);
                chk(new_pc == 32'hFFFF_FFD0, "R7 dup vector", new_pc, 32'hFFFF_FFD0);
            end else begin
                chk(norm_save_we && !dup_save_we, "R5 norm write", {30'h0, dup_save_we, norm_save_we}, 32'h1);
                chk(new_pc == vec, "R5/R6 vector", new_pc, vec);
            end
        end else begin
            chk(busy && dump_valid && !entry_done, "R8 dump start", {29'h0, busy, dump_valid, entry_done}, 32'h6);
            irq_req = ~irq; exc_code = 16'h1234; cur_pc = ~pc; cur_psw = ~psw;
            @(negedge clk);
            accept = 1'b0;
            chk(dump_addr == 0 && dump_data == ({16'hFFFF, code}), "R8/R11 hold word0", dump_data, {16'hFFFF, code});
            for (int k = 0; k < 3; k++) begin
                logic [31:0] ed;
                ed = (k == 0) ? {16'hFFFF, code} : (k == 1) ? psw : pc;
                chk(dump_valid && dump_addr == 32'(4 * k), "R8 dump addr", dump_addr, 32'(4 * k));
                chk(dump_data == ed, "R8 dump data", dump_data, ed);
                chk(!entry_done, "R8 no early done", 32'(entry_done), 32'h0);
                dump_ack = 1'b1;
                @(negedge clk);
                dump_ack = 1'b0;
            end
            chk(entry_done && !busy && !norm_save_we && !dup_save_we, "R8 fatal done",
                {28'h0, entry_done, busy, norm_save_we, dup_save_we}, 32'h8);
            chk(new_pc == 32'hFFFF_FFD0, "R8 fatal vector", new_pc, 32'hFFFF_FFD0);
            chk(new_psw == exp_psw(psw, code), "R9 fatal psw", new_psw, exp_psw(psw, code));
        end
        accept = 1'b0;
    endtask

    initial begin
        logic [15:0] codes [4];
        codes[0] = 16'h0000; codes[1] = 16'hFF90; codes[2] = 16'hFE30; codes[3] = 16'hFF70;
        repeat (3) @(negedge clk);
        chk(!entry_done && !busy && !dump_valid && !norm_save_we && !dup_save_we, "R1 reset",
            {27'h0, entry_done, busy, dump_valid, norm_save_we, dup_save_we}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!entry_done && !busy && !dump_valid, "R1 after reset", {29'h0, entry_done, busy, dump_valid}, 32'h0);
        for (int ir = 0; ir < 32; ir++)
            for (int f = 0; f < 8; f++)
                for (int e = 0; e < 4; e++)
                    run_vec(5'(ir), 3'(f), codes[e], 32'h0700_0000 + 32'((ir * 32 + f * 4 + e) * 2));
        @(negedge clk);
        chk(!entry_done, "R11 idle quiet", 32'(entry_done), 32'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule